// File: doc/BRIEF.md
# Framebuffer Control Register File

This block is the register slave that a processor writes to configure a palette-based framebuffer. It owns the colour lookup table (256 entries of red, green and blue), the visible width and height, and a control word whose blanking bit tells the display side to show black. Writes arrive one per clock on a simple bus carrying an address, a 32-bit data word, a write enable and a transfer size. Each transfer is broken into byte updates that are applied in ascending address order within the same clock.

The display side reads the palette through a combinational lookup port, using a pixel index. It also sees the current geometry and the blanking flag. A one-clock change pulse follows every write, so the display can schedule a full redraw. Width and height are built from byte writes whose bit positions overlap and do not line up with byte boundaries. Their sequencing is therefore part of the block's behaviour. Register reads always return zero.

Top module: `fbc_regfile`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and after it is released, every palette entry reads zero, width and height are zero, the blanking flag is low and the change pulse is low.
- R2: A byte write to an address below 0x0800 updates palette entry address>>3. Address bits 2:0 pick the component: 0 is red, 1 is green and 2 is blue. On the lookup port red is bits 23:16, green is bits 15:8 and blue is bits 7:0.
- R3: A palette-range byte write whose address bits 2:0 are 3 to 7 leaves every palette entry unchanged.
- R4: A byte write to 0x0918 places the data byte in width bits 9:2 and keeps all other width bits.
- R5: A byte write to 0x0919 places the data byte in width bits 17:10 and keeps all other width bits.
- R6: A byte write to 0x0940 places the data byte shifted right by one in height bits 6:0 and keeps height bits 14:7.
- R7: A byte write to 0x0941 clears height bits 14:5 and then places the data byte in bits 14:7. Height bits 4:0 are kept, so bits 6:5 end up zero.
- R8: Size code 0 is a byte, 1 is a halfword and 2 or 3 is a word. Byte k of the data (bits 8k+7:8k) goes to address+k. All bytes take effect in the same clock, applied in ascending address order.
- R9: Only address bits 15:0 are decoded. Bits above them are ignored, and address+k wraps within 16 bits.
- R10: The read data output is always zero.
- R11: The change pulse is high for exactly the clock after each write cycle, whatever the address. It is low after a cycle with no write. A write to an address no register decodes changes no state.
- R12: The 32-bit control word sits at 0x0A00–0x0A03 in little-endian byte order. Its bit 10 drives the blanking flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the transfer |
| bus_wdata | input | 32 | Write data, byte k for address+k |
| bus_we | input | 1 | Write strobe, one transfer per clock |
| bus_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| bus_rdata | output | 32 | Read data, constant zero |
| pal_idx | input | 8 | Palette lookup index |
| pal_rgb | output | 24 | Looked-up colour {red, green, blue} |
| disp_width | output | 18 | Display width register |
| disp_height | output | 15 | Display height register |
| force_blank | output | 1 | Blanking flag (control bit 10) |
| fb_changed | output | 1 | One-clock pulse after every write |

## Verification
Single-byte writes hit each palette component, the ignored component slots, and each geometry byte in turn. These show that the per-offset masks and shifts are correct on their own. Halfword and word writes across the height pair, the width pair plus an undecoded neighbour, a palette entry and the control word show that lane order and lane data selection are right. The height pair is where the order is visible, because the later byte clears bits that the earlier byte set. Addresses with high bits set, a word that wraps past 0xFFFF, an undecoded write and idle cycles separate a correct 16-bit decode and change pulse from over-decoding or a pulse that sticks. A second reset in mid-run confirms that everything returns to zero.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

    localparam int DEC_W = 16;

    // Register offsets; bit placement inside the geometry fields depends on these
    localparam logic [DEC_W-1:0] OFS_WID_LO = 16'h0918;
    localparam logic [DEC_W-1:0] OFS_WID_HI = 16'h0919;
    localparam logic [DEC_W-1:0] OFS_HGT_LO = 16'h0940;
    localparam logic [DEC_W-1:0] OFS_HGT_HI = 16'h0941;
    localparam logic [DEC_W-1:0] OFS_CTL    = 16'h0A00;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PAL,
        TGT_WID_LO,
        TGT_WID_HI,
        TGT_HGT_LO,
        TGT_HGT_HI,
        TGT_CTL
    } tgt_e;

    // One decoded byte update
    typedef struct packed {
        logic             hit;
        tgt_e             tgt;
        logic [DEC_W-1:0] ofs;
        logic [7:0]       data;
    } lane_t;

endpackage

// File: rtl/fbc_byte_decode.sv
module fbc_byte_decode
    import fbc_pkg::*;
#(
    parameter int PAL_ENTRIES = 256,
    parameter int CTRL_BYTES  = 4
) (
    input  logic             en,
    input  logic [DEC_W-1:0] addr,
    input  logic [7:0]       data,
    output lane_t            lane
);

    localparam logic [DEC_W-1:0] PAL_SPAN = DEC_W'(PAL_ENTRIES * 8);
    localparam logic [DEC_W-1:0] CTL_END  = OFS_CTL + DEC_W'(CTRL_BYTES);

    always_comb begin
        lane.hit  = en;
        lane.data = data;
        lane.ofs  = addr;
        lane.tgt  = TGT_NONE;
        if (addr < PAL_SPAN) begin
            lane.tgt = TGT_PAL;
        end else if (addr == OFS_WID_LO) begin
            lane.tgt = TGT_WID_LO;
        end else if (addr == OFS_WID_HI) begin
            lane.tgt = TGT_WID_HI;
        end else if (addr == OFS_HGT_LO) begin
            lane.tgt = TGT_HGT_LO;
        end else if (addr == OFS_HGT_HI) begin
            lane.tgt = TGT_HGT_HI;
        end else if (addr >= OFS_CTL && addr < CTL_END) begin
            lane.tgt = TGT_CTL;
            lane.ofs = addr - OFS_CTL;
        end
    end

endmodule

// File: rtl/fbc_palette.sv
module fbc_palette
    import fbc_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int LANES   = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  lane_t [LANES-1:0]     lanes,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [23:0]           rd_rgb
);

    // component 0 red, 1 green, 2 blue
    typedef logic [2:0][7:0] rgb_t;

    rgb_t pal_q [ENTRIES];
    rgb_t pal_d [ENTRIES];

    logic unused_lanes;
    assign unused_lanes = ^lanes;

    always_comb begin
        pal_d = pal_q;
        for (int k = 0; k < LANES; k++) begin
            if (lanes[k].hit && lanes[k].tgt == TGT_PAL && lanes[k].ofs[2:0] < 3'd3) begin
                pal_d[lanes[k].ofs[3 +: IDX_W]][lanes[k].ofs[1:0]] = lanes[k].data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                pal_q[e] <= '0;
            end
        end else begin
            pal_q <= pal_d;
        end
    end

    assign rd_rgb = {pal_q[rd_idx][0], pal_q[rd_idx][1], pal_q[rd_idx][2]};

endmodule

// File: rtl/fbc_geometry.sv
module fbc_geometry
    import fbc_pkg::*;
#(
    parameter int LANES     = 4,
    parameter int WIDTH_W   = 18,
    parameter int HEIGHT_W  = 15,
    parameter int CTRL_W    = 32,
    parameter int BLANK_BIT = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  lane_t [LANES-1:0]   lanes,
    input  logic                wr_any,
    output logic [WIDTH_W-1:0]  width,
    output logic [HEIGHT_W-1:0] height,
    output logic                blank,
    output logic                changed
);

    localparam int CTRL_BYTES = CTRL_W / 8;
    localparam int CB_W       = (CTRL_BYTES > 1) ? $clog2(CTRL_BYTES) : 1;

    typedef struct packed {
        logic [WIDTH_W-1:0]  width;
        logic [HEIGHT_W-1:0] height;
        logic [CTRL_W-1:0]   ctrl;
        logic                changed;
    } geo_t;

    geo_t s_d, s_q;

    logic unused_lanes;
    assign unused_lanes = ^lanes;

    always_comb begin
        s_d         = s_q;
        s_d.changed = wr_any;
        // ascending lane order: a later byte sees the earlier one's result
        for (int k = 0; k < LANES; k++) begin
            if (lanes[k].hit) begin
                case (lanes[k].tgt)
                    TGT_WID_LO: s_d.width[9:2]   = lanes[k].data;
                    TGT_WID_HI: s_d.width[17:10] = lanes[k].data;
                    TGT_HGT_LO: s_d.height[6:0]  = lanes[k].data[7:1];
                    TGT_HGT_HI: s_d.height[14:5] = {lanes[k].data, 2'b00};
                    TGT_CTL:    s_d.ctrl[{lanes[k].ofs[CB_W-1:0], 3'b000} +: 8] = lanes[k].data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign width   = s_q.width;
    assign height  = s_q.height;
    assign blank   = s_q.ctrl[BLANK_BIT];
    assign changed = s_q.changed;

endmodule

// File: rtl/fbc_regfile.sv
module fbc_regfile
    import fbc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int PAL_ENTRIES = 256,
    parameter int WIDTH_W     = 18,
    parameter int HEIGHT_W    = 15,
    parameter int CTRL_W      = 32,
    parameter int BLANK_BIT   = 10,
    localparam int IDX_W      = $clog2(PAL_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_we,
    input  logic [1:0]          bus_size,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IDX_W-1:0]    pal_idx,
    output logic [23:0]         pal_rgb,
    output logic [WIDTH_W-1:0]  disp_width,
    output logic [HEIGHT_W-1:0] disp_height,
    output logic                force_blank,
    output logic                fb_changed
);

    localparam int LANES = DATA_W / 8;

    lane_t [LANES-1:0] lanes;
    int                n_bytes;

    logic unused_hi;
    assign unused_hi = ^bus_addr[ADDR_W-1:DEC_W];

    always_comb begin
        case (bus_size)
            2'd0:    n_bytes = 1;
            2'd1:    n_bytes = 2;
            default: n_bytes = LANES;
        endcase
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [DEC_W-1:0] lane_addr;
        logic             lane_on;
        assign lane_addr = bus_addr[DEC_W-1:0] + DEC_W'(k);
        assign lane_on   = bus_we && (k < n_bytes);
        fbc_byte_decode #(
            .PAL_ENTRIES (PAL_ENTRIES),
            .CTRL_BYTES  (CTRL_W / 8)
        ) u_dec (
            .en   (lane_on),
            .addr (lane_addr),
            .data (bus_wdata[8*k +: 8]),
            .lane (lanes[k])
        );
    end

    fbc_palette #(
        .ENTRIES (PAL_ENTRIES),
        .LANES   (LANES)
    ) u_pal (
        .clk    (clk),
        .rst_n  (rst_n),
        .lanes  (lanes),
        .rd_idx (pal_idx),
        .rd_rgb (pal_rgb)
    );

    fbc_geometry #(
        .LANES     (LANES),
        .WIDTH_W   (WIDTH_W),
        .HEIGHT_W  (HEIGHT_W),
        .CTRL_W    (CTRL_W),
        .BLANK_BIT (BLANK_BIT)
    ) u_geo (
        .clk     (clk),
        .rst_n   (rst_n),
        .lanes   (lanes),
        .wr_any  (bus_we),
        .width   (disp_width),
        .height  (disp_height),
        .blank   (force_blank),
        .changed (fb_changed)
    );

    assign bus_rdata = '0;

endmodule

// File: rtl/fbc_regfile_chk.sv
module fbc_regfile_chk #(
    parameter int WIDTH_W  = 18,
    parameter int HEIGHT_W = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic [15:0]         addr_lo,
    input logic [1:0]          size,
    input logic                we,
    input logic [WIDTH_W-1:0]  width,
    input logic [HEIGHT_W-1:0] height,
    input logic                blank,
    input logic                changed
);

    logic byte_wid_lo, byte_hgt_hi;
    assign byte_wid_lo = we && size == 2'd0 && addr_lo == 16'h0918;
    assign byte_hgt_hi = we && size == 2'd0 && addr_lo == 16'h0941;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (width == '0 && height == '0 && !blank && !changed));

    p_pulse_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> changed);

    p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> !changed);

    p_geom_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(width) && $stable(height) && $stable(blank)));

    p_wid_lo_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wid_lo |=> (width[1:0] == $past(width[1:0]) && width[17:10] == $past(width[17:10])));

    p_hgt_hi_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_hgt_hi |=> (height[4:0] == $past(height[4:0]) && height[6:5] == 2'b00));

endmodule

bind fbc_regfile fbc_regfile_chk #(
    .WIDTH_W  (WIDTH_W),
    .HEIGHT_W (HEIGHT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_lo (bus_addr[15:0]),
    .size    (bus_size),
    .we      (bus_we),
    .width   (disp_width),
    .height  (disp_height),
    .blank   (force_blank),
    .changed (fb_changed)
);

// File: tb/test_fbc_regfile.sv
module test_fbc_regfile;

    localparam int CLK_P = 20;

    localparam int K_W   = 0;
    localparam int K_H   = 1;
    localparam int K_B   = 2;
    localparam int K_C   = 3;
    localparam int K_RD  = 4;
    localparam int K_RGB = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_we;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata;
    logic [7:0]  pal_idx;
    logic [23:0] pal_rgb;
    logic [17:0] disp_width;
    logic [14:0] disp_height;
    logic        force_blank;
    logic        fb_changed;

    always #(CLK_P/2) clk = ~clk;

    fbc_regfile i_fbc_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .bus_size    (bus_size),
        .bus_rdata   (bus_rdata),
        .pal_idx     (pal_idx),
        .pal_rgb     (pal_rgb),
        .disp_width  (disp_width),
        .disp_height (disp_height),
        .force_blank (force_blank),
        .fb_changed  (fb_changed)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model built from the requirements
    logic [7:0]  m_pal [256][3];
    logic [17:0] m_w;
    logic [14:0] m_h;
    logic [31:0] m_c;

    typedef struct {
        string       tag;
        int          kind;
        int          idx;
        logic [31:0] exp;
    } item_t;

    item_t sb[$];

    task automatic push(string tag, int kind, int idx, logic [31:0] exp);
        item_t it;
        it.tag  = tag;
        it.kind = kind;
        it.idx  = idx;
        it.exp  = exp;
        sb.push_back(it);
    endtask

    function automatic logic [31:0] m_rgb(int i);
        return {8'h00, m_pal[i][0], m_pal[i][1], m_pal[i][2]};
    endfunction

    task automatic push_state(string tag, logic chg);
        push(tag, K_W, 0, 32'(m_w));
        push(tag, K_H, 0, 32'(m_h));
        push(tag, K_B, 0, 32'(m_c[10]));
        push(tag, K_C, 0, 32'(chg));
        push("R10", K_RD, 0, 32'h0);
    endtask

    task automatic m_clear();
        for (int i = 0; i < 256; i++) begin
            for (int c = 0; c < 3; c++) m_pal[i][c] = 8'h00;
        end
        m_w = '0;
        m_h = '0;
        m_c = '0;
    endtask

    task automatic m_byte(logic [15:0] a, logic [7:0] d);
        if (a < 16'h0800) begin
            if (a[2:0] < 3'd3) m_pal[a[10:3]][a[1:0]] = d;
        end else begin
            case (a)
                16'h0918: m_w = (m_w & ~18'h003FC) | (18'(d) << 2);
                16'h0919: m_w = (m_w & ~18'h3FC00) | (18'(d) << 10);
                16'h0940: m_h = (m_h & ~15'h007F) | 15'(d >> 1);
                16'h0941: m_h = (m_h & 15'h001F) | (15'(d) << 7);
                16'h0A00: m_c[7:0]   = d;
                16'h0A01: m_c[15:8]  = d;
                16'h0A02: m_c[23:16] = d;
                16'h0A03: m_c[31:24] = d;
                default: ;
            endcase
        end
    endtask

    // driver: one write, model update, expectations for the following clock
    task automatic wr(logic [31:0] a, logic [31:0] d, logic [1:0] sz, string tag);
        int n;
        logic [15:0] la;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_size  = sz;
        bus_we    = 1'b1;
        for (int k = 0; k < n; k++) begin
            la = a[15:0] + 16'(k);
            m_byte(la, d[8*k +: 8]);
        end
        @(posedge clk);
        push_state(tag, 1'b1);
        for (int k = 0; k < n; k++) begin
            la = a[15:0] + 16'(k);
            if (la < 16'h0800) push(tag, K_RGB, int'(la[10:3]), m_rgb(int'(la[10:3])));
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(string tag);
        @(posedge clk);
        push_state(tag, 1'b0);
    endtask

    // monitor: pops expectations and compares against the ports
    initial begin
        pal_idx = 8'h00;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            while (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_W:   act = 32'(disp_width);
                    K_H:   act = 32'(disp_height);
                    K_B:   act = 32'(force_blank);
                    K_C:   act = 32'(fb_changed);
                    K_RD:  act = bus_rdata;
                    default: begin
                        pal_idx = 8'(it.idx);
                        #1;
                        act = 32'(pal_rgb);
                    end
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h",
                             it.tag, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_size  = 2'd0;
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        push_state("R1", 1'b0);
        push("R1", K_RGB, 0, 32'h0);
        push("R1", K_RGB, 255, 32'h0);

        // R2: individual components, first and last entries
        wr(32'h0000_0028, 32'h11, 2'd0, "R2");
        wr(32'h0000_0029, 32'h22, 2'd0, "R2");
        wr(32'h0000_002A, 32'h33, 2'd0, "R2");
        wr(32'h0000_07FA, 32'hC3, 2'd0, "R2");
        wr(32'h0000_0000, 32'h9E, 2'd0, "R2");
        // R3: unused component slots
        wr(32'h0000_002B, 32'hFF, 2'd0, "R3");
        wr(32'h0000_002F, 32'hFF, 2'd0, "R3");
        wr(32'h0000_0033, 32'hEE, 2'd0, "R3");
        push("R3", K_RGB, 6, m_rgb(6));
        // R4 / R5: width bytes
        wr(32'h0000_0918, 32'hFF, 2'd0, "R4");
        wr(32'h0000_0919, 32'h03, 2'd0, "R5");
        wr(32'h0000_0918, 32'h00, 2'd0, "R4");
        wr(32'h0000_0919, 32'hA5, 2'd0, "R5");
        // R6 / R7: height bytes
        wr(32'h0000_0940, 32'hFF, 2'd0, "R6");
        wr(32'h0000_0941, 32'h01, 2'd0, "R7");
        wr(32'h0000_0940, 32'h5A, 2'd0, "R6");
        wr(32'h0000_0941, 32'hFF, 2'd0, "R7");
        // R8: halfword and word splits
        wr(32'h0000_0940, 32'h0000_ABCD, 2'd1, "R8");
        wr(32'h0000_0918, 32'h1234_5678, 2'd2, "R8");
        wr(32'h0000_0040, 32'hDDCC_BBAA, 2'd3, "R8");
        wr(32'h0000_0030, 32'h0000_7766, 2'd1, "R8");
        // R9: high address bits ignored, 16-bit wrap
        wr(32'hFFFF_0918, 32'h01, 2'd0, "R9");
        wr(32'h0001_0029, 32'h4C, 2'd0, "R9");
        wr(32'h0000_FFFE, 32'h8877_6655, 2'd2, "R9");
        // R11: undecoded write and idle cycles
        wr(32'h0000_3000, 32'hFFFF_FFFF, 2'd2, "R11");
        idle("R11");
        idle("R11");
        // R12: control word and blanking bit
        wr(32'h0000_0A00, 32'h0000_0400, 2'd2, "R12");
        wr(32'h0000_0A01, 32'h00, 2'd0, "R12");
        wr(32'h0000_0A01, 32'hFB, 2'd0, "R12");
        wr(32'h0000_0A01, 32'h04, 2'd0, "R12");
        wr(32'h0000_0A03, 32'h0000_FF00, 2'd1, "R12");
        idle("R11");

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_clear();
        @(posedge clk);
        push_state("R1", 1'b0);
        push("R1", K_RGB, 5, 32'h0);
        push("R1", K_RGB, 8, 32'h0);
        push("R1", K_RGB, 255, 32'h0);

        while (sb.size() != 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule